// File: doc/BRIEF.md
# Long-Delay One-Shot Timer

This block is a digital monostable timer for very long delays. A free-running oscillator supplies a tick enable, and every piece of timing is counted in those ticks. A binary divider of `DIV_STAGES` stages measures the pulse: a start request raises the output, and the output falls when the divider's most significant stage first sets. That takes 2^(DIV_STAGES-1) ticks, which is 524,288 ticks at the default width. A second request input toggles the output. That input passes through a glitch filter that counts ticks, so short spikes are discarded. A clear input forces the output low and holds the divider at zero. It also takes priority over both request inputs.

If the clear input rises while a request input is already high, the block does not perform a normal clear. It enters a factory test mode instead. In that mode the divider advances one step per rising edge of a separate step input rather than per oscillator tick. This lets the full divider chain be checked in a short time. A power-on clear input returns the whole block to its idle state.

Top module: `lmt_oneshot`

## Requirements
- R1: A rising edge on `start_in`, seen while `clear_in` is low in normal mode, raises `pulse_out` and restarts the divider from zero. `pulse_out` goes high within 4 ticks of the input rising (with `SYNC_STAGES`=2).
- R2: Once started and left undisturbed, `pulse_out` stays high for exactly 2^(DIV_STAGES-1) ticks and then falls.
- R3: While `clear_in` is high in normal mode, `pulse_out` is low, the divider is held at zero, and rising edges on `start_in` and `toggle_in` have no effect. If `clear_in` and `start_in` rise in the same tick, the clear wins and normal mode is kept.
- R4: An accepted rising edge on `toggle_in` inverts `pulse_out`. Going from low to high starts a full timed pulse. Going from high to low stops the divider and clears it.
- R5: A `toggle_in` high time of 7 ticks or fewer is rejected. A high time of at least `TRIG_ACCEPT` ticks is accepted. `TRIG_ACCEPT` must lie in 8..16 and defaults to 8.
- R6: A rising edge on `clear_in` while `start_in` or `toggle_in` was already high on the previous tick enters test mode. `pulse_out` keeps its value and the divider is cleared. In test mode, edges on `start_in` and `toggle_in` are ignored.
- R7: In test mode the divider advances once per rising edge of `test_step_in` and never on oscillator ticks alone. `pulse_out` falls on the step that sets the top stage, which is step 2^(DIV_STAGES-1) after entry.
- R8: In test mode, a rising edge on `clear_in` while both `start_in` and `toggle_in` are low returns the block to normal mode with `pulse_out` low.
- R9: While `por_clr` is high, `pulse_out` is low from the next clock, every input is ignored, and the block is in normal mode when `por_clr` falls.
- R10: Apart from `por_clr`, no state changes on a clock edge where `osc_tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_clr | input | 1 | Power-on clear, active high, synchronous |
| osc_tick | input | 1 | One-cycle enable marking each oscillator period |
| start_in | input | 1 | Pulse start request (rising edge) |
| clear_in | input | 1 | Clear level, also selects test mode on an illegal overlap |
| toggle_in | input | 1 | Filtered toggle request (rising edge) |
| test_step_in | input | 1 | Divider step used only in test mode |
| pulse_out | output | 1 | Timed output |

## Verification
The assertions assume three things. `por_clr` is raised at time zero. Every input changes away from the clock edge. `osc_tick` is a clean enable that is steady across each edge. The stimulus meets these assumptions. It drives all inputs on the falling clock edge. It generates the tick as a register that alternates every cycle and freezes at zero during the stall scenario. It holds every request high and low for whole ticks, so each synchroniser sees each level for at least one tick. Test-mode steps are spaced two ticks high and two ticks low, so every step edge is counted once.

// File: rtl/lmt_pkg.sv
package lmt_pkg;
   typedef enum logic {
      MODE_RUN  = 1'b0,
      MODE_TEST = 1'b1
   } lmt_mode_e;

   // bit positions of the request inputs inside the synchroniser vector
   localparam int IDX_START  = 0;
   localparam int IDX_CLEAR  = 1;
   localparam int IDX_TOGGLE = 2;
   localparam int IDX_STEP   = 3;
   localparam int N_CTRL     = 4;
endpackage

// File: rtl/lmt_sync.sv
module lmt_sync #(
   parameter int N_BITS = 4,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              por_clr,
   input  logic              tick,
   input  logic [N_BITS-1:0] din,
   output logic [N_BITS-1:0] lvl,
   output logic [N_BITS-1:0] dly
);
   initial begin : p_cfg
      if (STAGES < 1) $fatal(1, "lmt_sync: STAGES must be at least 1");
      if (N_BITS < 1) $fatal(1, "lmt_sync: N_BITS must be at least 1");
   end

   for (genvar b = 0; b < N_BITS; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      logic              prev;

      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (por_clr)   chain <= '0;
            else if (tick) chain <= din[b];
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (por_clr)   chain <= '0;
            else if (tick) chain <= {chain[STAGES-2:0], din[b]};
         end
      end

      always_ff @(posedge clk) begin
         if (por_clr)   prev <= 1'b0;
         else if (tick) prev <= chain[STAGES-1];
      end

      assign lvl[b] = chain[STAGES-1];
      assign dly[b] = prev;
   end
endmodule

// File: rtl/lmt_trig_filter.sv
module lmt_trig_filter #(
   parameter int CNT_W  = 4,
   parameter int ACCEPT = 8
) (
   input  logic clk,
   input  logic por_clr,
   input  logic tick,
   input  logic level,
   output logic act
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ACCEPT);

   initial begin : p_cfg
      if (ACCEPT < 8 || ACCEPT > 16)
         $fatal(1, "lmt_trig_filter: ACCEPT must lie in 8..16");
      if (ACCEPT > (1 << CNT_W) - 1)
         $fatal(1, "lmt_trig_filter: CNT_W too narrow for ACCEPT");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (por_clr) begin
         cnt_q <= '0;
      end else if (tick) begin
         if (!level)              cnt_q <= '0;
         else if (cnt_q != LIMIT) cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign act = (cnt_q == LIMIT);
endmodule

// File: rtl/lmt_divider.sv
module lmt_divider #(
   parameter int STAGES = 20
) (
   input  logic              clk,
   input  logic              por_clr,
   input  logic              tick,
   input  logic              clr,
   input  logic              inc,
   output logic [STAGES-1:0] cnt_o,
   output logic              top_hit
);
   initial begin : p_cfg
      if (STAGES < 2) $fatal(1, "lmt_divider: STAGES must be at least 2");
   end

   logic [STAGES-1:0] q;
   logic [STAGES-1:0] carry;

   assign carry[0] = tick & inc & ~clr;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (por_clr)          q[i] <= 1'b0;
         else if (tick && clr) q[i] <= 1'b0;
         else if (carry[i])    q[i] <= ~q[i];
      end
      if (i < STAGES - 1) begin : g_carry
         assign carry[i+1] = carry[i] & q[i];
      end
   end

   assign cnt_o   = q;
   assign top_hit = carry[STAGES-1] & ~q[STAGES-1];
endmodule

// File: rtl/lmt_ctrl.sv
module lmt_ctrl
   import lmt_pkg::*;
(
   input  logic      clk,
   input  logic      por_clr,
   input  logic      tick,
   input  logic      start_lvl,
   input  logic      start_dly,
   input  logic      clear_lvl,
   input  logic      clear_dly,
   input  logic      tog_lvl,
   input  logic      tog_dly,
   input  logic      step_lvl,
   input  logic      step_dly,
   input  logic      tog_act,
   input  logic      top_hit,
   output logic      div_clr,
   output logic      div_inc,
   output logic      pulse_q,
   output lmt_mode_e mode_q
);
   logic      run_q, run_n;
   logic      pulse_n;
   lmt_mode_e mode_n;
   logic      act_d;

   logic start_rise, clear_rise, step_rise, tog_rise;
   assign start_rise = start_lvl & ~start_dly;
   assign clear_rise = clear_lvl & ~clear_dly;
   assign step_rise  = step_lvl & ~step_dly;
   assign tog_rise   = tog_act & ~act_d;

   always_comb begin
      mode_n  = mode_q;
      pulse_n = pulse_q;
      run_n   = run_q;
      div_clr = 1'b0;
      div_inc = 1'b0;
      unique case (mode_q)
         MODE_RUN: begin
            if (clear_lvl) begin
               div_clr = 1'b1;
               run_n   = 1'b0;
               if (clear_rise && (start_dly || tog_dly)) mode_n  = MODE_TEST;
               else                                      pulse_n = 1'b0;
            end else if (start_rise) begin
               pulse_n = 1'b1;
               run_n   = 1'b1;
               div_clr = 1'b1;
            end else if (tog_rise) begin
               pulse_n = ~pulse_q;
               run_n   = ~pulse_q;
               div_clr = 1'b1;
            end else if (run_q) begin
               div_inc = 1'b1;
               if (top_hit) begin
                  pulse_n = 1'b0;
                  run_n   = 1'b0;
               end
            end else begin
               div_clr = 1'b1;
            end
         end
         MODE_TEST: begin
            if (clear_rise && !start_lvl && !tog_lvl) begin
               mode_n  = MODE_RUN;
               pulse_n = 1'b0;
               div_clr = 1'b1;
            end else begin
               div_inc = step_rise;
               if (top_hit) pulse_n = 1'b0;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (por_clr) begin
         mode_q  <= MODE_RUN;
         pulse_q <= 1'b0;
         run_q   <= 1'b0;
         act_d   <= 1'b0;
      end else if (tick) begin
         mode_q  <= mode_n;
         pulse_q <= pulse_n;
         run_q   <= run_n;
         act_d   <= tog_act;
      end
   end
endmodule

// File: rtl/lmt_oneshot.sv
module lmt_oneshot
   import lmt_pkg::*;
#(
   parameter int DIV_STAGES  = 20,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_W      = 4,
   parameter int TRIG_ACCEPT = 8
) (
   input  logic clk,
   input  logic por_clr,
   input  logic osc_tick,
   input  logic start_in,
   input  logic clear_in,
   input  logic toggle_in,
   input  logic test_step_in,
   output logic pulse_out
);
   logic [N_CTRL-1:0]     raw_req;
   logic [N_CTRL-1:0]     sync_lvl;
   logic [N_CTRL-1:0]     sync_dly;
   logic                  tog_act;
   logic                  div_clr, div_inc, top_hit;
   logic [DIV_STAGES-1:0] div_cnt;
   lmt_mode_e             mode_q;

   always_comb begin
      raw_req             = '0;
      raw_req[IDX_START]  = start_in;
      raw_req[IDX_CLEAR]  = clear_in;
      raw_req[IDX_TOGGLE] = toggle_in;
      raw_req[IDX_STEP]   = test_step_in;
   end

   lmt_sync #(.N_BITS(N_CTRL), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .por_clr(por_clr), .tick(osc_tick),
      .din(raw_req), .lvl(sync_lvl), .dly(sync_dly)
   );

   lmt_trig_filter #(.CNT_W(FILT_W), .ACCEPT(TRIG_ACCEPT)) u_filt (
      .clk(clk), .por_clr(por_clr), .tick(osc_tick),
      .level(sync_lvl[IDX_TOGGLE]), .act(tog_act)
   );

   lmt_divider #(.STAGES(DIV_STAGES)) u_div (
      .clk(clk), .por_clr(por_clr), .tick(osc_tick),
      .clr(div_clr), .inc(div_inc), .cnt_o(div_cnt), .top_hit(top_hit)
   );

   lmt_ctrl u_ctrl (
      .clk(clk), .por_clr(por_clr), .tick(osc_tick),
      .start_lvl(sync_lvl[IDX_START]),  .start_dly(sync_dly[IDX_START]),
      .clear_lvl(sync_lvl[IDX_CLEAR]),  .clear_dly(sync_dly[IDX_CLEAR]),
      .tog_lvl(sync_lvl[IDX_TOGGLE]),   .tog_dly(sync_dly[IDX_TOGGLE]),
      .step_lvl(sync_lvl[IDX_STEP]),    .step_dly(sync_dly[IDX_STEP]),
      .tog_act(tog_act), .top_hit(top_hit),
      .div_clr(div_clr), .div_inc(div_inc),
      .pulse_q(pulse_out), .mode_q(mode_q)
   );
endmodule

// File: rtl/lmt_oneshot_chk.sv
module lmt_oneshot_chk
   import lmt_pkg::*;
#(
   parameter int DIV_STAGES = 20
) (
   input logic                  clk,
   input logic                  por_clr,
   input logic                  osc_tick,
   input logic                  pulse_out,
   input lmt_mode_e             mode_q,
   input logic                  st_lvl,
   input logic                  st_dly,
   input logic                  clr_lvl,
   input logic                  clr_dly,
   input logic                  stp_lvl,
   input logic                  stp_dly,
   input logic [DIV_STAGES-1:0] div_cnt
);
   localparam logic [DIV_STAGES-1:0] HALF = DIV_STAGES'(1) << (DIV_STAGES - 1);

   p_start_r1: assert property (@(posedge clk) disable iff (por_clr)
      (osc_tick && mode_q == MODE_RUN && st_lvl && !st_dly && !clr_lvl)
      |=> (pulse_out && div_cnt == '0));

   p_div_bound_r2: assert property (@(posedge clk) disable iff (por_clr)
      (mode_q == MODE_RUN) |-> (div_cnt <= HALF));

   p_clear_low_r3: assert property (@(posedge clk) disable iff (por_clr)
      (osc_tick && mode_q == MODE_RUN && clr_lvl)
      |=> (!pulse_out || mode_q == MODE_TEST));

   p_test_hold_r7: assert property (@(posedge clk) disable iff (por_clr)
      (osc_tick && mode_q == MODE_TEST && !(stp_lvl && !stp_dly) && !(clr_lvl && !clr_dly))
      |=> $stable(div_cnt));

   p_no_tick_r10: assert property (@(posedge clk) disable iff (por_clr)
      (!osc_tick) |=> ($stable(pulse_out) && $stable(div_cnt) && $stable(mode_q)));

   p_por_r9: assert property (@(posedge clk)
      por_clr |=> (!pulse_out && mode_q == MODE_RUN));
endmodule

bind lmt_oneshot lmt_oneshot_chk #(.DIV_STAGES(DIV_STAGES)) u_chk (
   .clk(clk), .por_clr(por_clr), .osc_tick(osc_tick), .pulse_out(pulse_out),
   .mode_q(mode_q),
   .st_lvl(sync_lvl[lmt_pkg::IDX_START]),  .st_dly(sync_dly[lmt_pkg::IDX_START]),
   .clr_lvl(sync_lvl[lmt_pkg::IDX_CLEAR]), .clr_dly(sync_dly[lmt_pkg::IDX_CLEAR]),
   .stp_lvl(sync_lvl[lmt_pkg::IDX_STEP]),  .stp_dly(sync_dly[lmt_pkg::IDX_STEP]),
   .div_cnt(div_cnt)
);

// File: tb/lmt_oneshot_tb_top.sv
module lmt_oneshot_tb_top;
   localparam int DIV   = 8;
   localparam int PULSE = 1 << (DIV - 1);

   logic clk = 1'b0;
   logic por_clr = 1'b1;
   logic osc_tick = 1'b0;
   logic tick_run = 1'b1;
   logic start_in = 1'b0, clear_in = 1'b0, toggle_in = 1'b0, test_step_in = 1'b0;
   logic pulse_out;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #4 clk = ~clk;

   always @(negedge clk) osc_tick <= tick_run ? ~osc_tick : 1'b0;

   lmt_oneshot #(.DIV_STAGES(DIV), .SYNC_STAGES(2), .FILT_W(4), .TRIG_ACCEPT(8)) dut_i (
      .clk(clk), .por_clr(por_clr), .osc_tick(osc_tick),
      .start_in(start_in), .clear_in(clear_in), .toggle_in(toggle_in),
      .test_step_in(test_step_in), .pulse_out(pulse_out)
   );

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: cycles=%0d expected fewer", cyc);
         summary();
      end
   end

   task automatic check_bit(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: pulse_out=%0b expected %0b", req, act, exp);
      end
   endtask

   task automatic check_int(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: value=%0d expected %0d", req, act, exp);
      end
   endtask

   task automatic next_tick();
      @(posedge clk iff osc_tick);
      @(negedge clk);
   endtask

   task automatic wait_ticks(input int n);
      repeat (n) next_tick();
   endtask

   task automatic pulse_start(input int hi);
      start_in = 1'b1; wait_ticks(hi); start_in = 1'b0;
   endtask

   task automatic pulse_toggle(input int hi);
      toggle_in = 1'b1; wait_ticks(hi); toggle_in = 1'b0;
   endtask

   task automatic t_por_state();
      repeat (4) @(negedge clk);
      check_bit("R9 output low under power-on clear", pulse_out, 1'b0);
      por_clr = 1'b0;
      wait_ticks(4);
      check_bit("R9 idle after power-on clear", pulse_out, 1'b0);
   endtask

   task automatic t_start_length();
      int lat = 0;
      int len = 0;
      start_in = 1'b1;
      while (!pulse_out && lat < 12) begin next_tick(); lat++; end
      start_in = 1'b0;
      check_int("R1 start latency within 4 ticks", (lat <= 4) ? 1 : 0, 1);
      while (pulse_out && len < 4 * PULSE) begin len++; next_tick(); end
      check_int("R2 pulse length in ticks", len, PULSE);
      check_bit("R2 output low after expiry", pulse_out, 1'b0);
   endtask

   task automatic t_clear();
      pulse_start(3);
      wait_ticks(6);
      check_bit("R1 pulse running before clear", pulse_out, 1'b1);
      clear_in = 1'b1;
      wait_ticks(5);
      check_bit("R3 clear forces low", pulse_out, 1'b0);
      pulse_start(3);
      pulse_toggle(10);
      wait_ticks(8);
      check_bit("R3 start and toggle ignored under clear", pulse_out, 1'b0);
      clear_in = 1'b0;
      wait_ticks(8);
      check_bit("R3 stays low after clear release", pulse_out, 1'b0);
   endtask

   task automatic t_simul();
      start_in = 1'b1; clear_in = 1'b1;
      wait_ticks(4);
      check_bit("R3 simultaneous clear wins", pulse_out, 1'b0);
      start_in = 1'b0; clear_in = 1'b0;
      wait_ticks(6);
      check_bit("R3 low after simultaneous release", pulse_out, 1'b0);
      pulse_start(3);
      wait_ticks(4);
      check_bit("R3 normal mode kept after overlap", pulse_out, 1'b1);
      clear_in = 1'b1; wait_ticks(4); clear_in = 1'b0; wait_ticks(4);
   endtask

   task automatic t_toggle();
      pulse_toggle(7);
      wait_ticks(15);
      check_bit("R5 seven-tick toggle rejected", pulse_out, 1'b0);
      pulse_toggle(16);
      wait_ticks(8);
      check_bit("R4 R5 sixteen-tick toggle raises output", pulse_out, 1'b1);
      pulse_toggle(16);
      wait_ticks(8);
      check_bit("R4 second toggle lowers output", pulse_out, 1'b0);
      pulse_toggle(8);
      wait_ticks(8);
      check_bit("R5 eight-tick toggle accepted", pulse_out, 1'b1);
      wait_ticks(PULSE);
      check_bit("R4 toggled pulse expires", pulse_out, 1'b0);
   endtask

   task automatic t_freeze();
      tick_run = 1'b0;
      repeat (3) @(negedge clk);
      start_in = 1'b1;
      repeat (20) @(negedge clk);
      check_bit("R10 no change without ticks", pulse_out, 1'b0);
      start_in = 1'b0;
      repeat (4) @(negedge clk);
      tick_run = 1'b1;
      wait_ticks(8);
      check_bit("R10 held request unseen without ticks", pulse_out, 1'b0);
   endtask

   task automatic t_test_mode();
      start_in = 1'b1;
      wait_ticks(6);
      check_bit("R1 pulse high before test entry", pulse_out, 1'b1);
      clear_in = 1'b1; wait_ticks(4);
      clear_in = 1'b0; wait_ticks(4);
      start_in = 1'b0; wait_ticks(4);
      check_bit("R6 output kept on test entry", pulse_out, 1'b1);
      wait_ticks(200);
      check_bit("R7 ticks alone do not advance divider", pulse_out, 1'b1);
      for (int i = 0; i < PULSE - 1; i++) begin
         test_step_in = 1'b1; wait_ticks(2);
         test_step_in = 1'b0; wait_ticks(2);
      end
      wait_ticks(4);
      check_bit("R7 still high one step short", pulse_out, 1'b1);
      test_step_in = 1'b1; wait_ticks(2);
      test_step_in = 1'b0; wait_ticks(4);
      check_bit("R7 low on final step", pulse_out, 1'b0);
      pulse_start(4);
      wait_ticks(8);
      check_bit("R6 start ignored in test mode", pulse_out, 1'b0);
      clear_in = 1'b1; wait_ticks(4);
      clear_in = 1'b0; wait_ticks(4);
      check_bit("R8 low after test exit", pulse_out, 1'b0);
      pulse_start(3);
      wait_ticks(4);
      check_bit("R8 normal start works after exit", pulse_out, 1'b1);
   endtask

   task automatic t_por_mid();
      por_clr = 1'b1;
      repeat (3) @(negedge clk);
      check_bit("R9 power-on clear drops running pulse", pulse_out, 1'b0);
      start_in = 1'b1;
      repeat (6) @(negedge clk);
      start_in = 1'b0;
      por_clr = 1'b0;
      wait_ticks(8);
      check_bit("R9 start during clear ignored", pulse_out, 1'b0);
   endtask

   initial begin
      t_por_state();
      t_start_length();
      t_clear();
      t_simul();
      t_toggle();
      t_freeze();
      t_test_mode();
      t_por_mid();
      summary();
   end
endmodule